// File: doc/BRIEF.md
# Per-Page Line Rotation Wear Leveler

This block spreads write wear across the line slots of each page frame in a wear-limited memory. Every resident frame owns a small rotation amount. A logical line index inside the page is translated to a physical slot by adding that amount modulo the number of lines per page. A hot line therefore lands on a different physical slot each time the frame is filled with a new page.

A free-running linear feedback shift register supplies the random rotation amounts. When the controller allocates or replaces a frame, it pulses an allocate strobe together with the frame index. The block then stores fresh random bits as that frame's rotation, and the value is held until the frame is allocated again.

The translate path is purely combinational. A lookup issued in the same cycle as the allocation of its own frame already sees the new rotation. Moving data and managing tags are left to the surrounding controller.

Top module: `page_line_rotator`

## Requirements
- R1: After reset every frame's rotation is zero, so `xlat_line_o` equals `xlat_line_i` for every frame until that frame is first allocated.
- R2: With a stored rotation s for the addressed frame, `xlat_line_o` equals (`xlat_line_i` + s) modulo 16, in the same cycle and with no register on the path. This includes the wrap from slot 15 back to slot 0.
- R3: A 16-bit generator is loaded with 16'hACE1 while reset is held. On every clock edge out of reset it moves to {g[14:0], g[15]^g[13]^g[12]^g[10]}. An allocate strobe sampled at an edge stores the low 4 bits of g as they stood just before that edge, and that value becomes the frame's rotation.
- R4: A frame's rotation stays unchanged over any number of cycles in which that frame is not allocated.
- R5: Allocating a frame that is already resident replaces its rotation with the value the generator holds at the new allocation edge.
- R6: When `alloc_i` is high and `alloc_frame_i` equals `xlat_frame_i`, the translation in that cycle already uses the rotation being captured. After the edge, the stored rotation is the same value.
- R7: Allocating one frame leaves the rotations of all other frames unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_i | input | 1 | Allocate or replace strobe for one frame |
| alloc_frame_i | input | FRAME_W (6) | Frame index being allocated |
| xlat_frame_i | input | FRAME_W (6) | Frame index of the line lookup |
| xlat_line_i | input | LINE_W (4) | Logical line within the page |
| xlat_line_o | output | LINE_W (4) | Physical line slot |

## Verification
Translation is first swept over all sixteen logical lines of unallocated frames. This separates a correct zero reset value from stale or uninitialised storage. After frames are allocated, full sweeps show whether the sum wraps modulo 16 or saturates. Comparing each captured rotation against a generator model stepped from the stated polynomial exposes an off-by-one capture edge. Long idle stretches, allocations of neighbouring frames, re-allocation of the same frame and a lookup colliding with its own allocation separate correct holding, isolation, refresh and same-cycle forwarding from stale or leaking behaviour.

// File: rtl/wl_pkg.sv
package wl_pkg;
  localparam int unsigned LFSR_W     = 16;
  localparam logic [15:0] LFSR_SEED  = 16'hACE1;
  localparam logic [15:0] LFSR_TAPS  = 16'hB400; // bits 15,13,12,10
endpackage

// File: rtl/wl_lfsr.sv
module wl_lfsr #(
  parameter int unsigned W = wl_pkg::LFSR_W,
  parameter logic [W-1:0] SEED = W'(wl_pkg::LFSR_SEED),
  parameter logic [W-1:0] TAPS = W'(wl_pkg::LFSR_TAPS)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb      = ^(state_q & TAPS);
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= {state_q[W-2:0], fb};
  end

  p_lfsr_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  p_lfsr_shift_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> state_q[W-1:1] == $past(state_q[W-2:0]));
endmodule

// File: rtl/wl_shift_file.sv
module wl_shift_file #(
  parameter int unsigned FRAMES  = 64,
  parameter int unsigned SHIFT_W = 4,
  localparam int unsigned IDX_W  = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [SHIFT_W-1:0] wr_val_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [SHIFT_W-1:0] rd_val_o
);
  logic [SHIFT_W-1:0] mem_q [FRAMES];
  logic               fwd;

  for (genvar k = 0; k < FRAMES; k++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      mem_q[k] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(k))        mem_q[k] <= wr_val_i;
    end

    p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_idx_i == IDX_W'(k)) |=> $stable(mem_q[k]));
  end

  // same-cycle write forwarding toward the read port
  assign fwd      = wr_en_i && (wr_idx_i == rd_idx_i);
  assign rd_val_o = fwd ? wr_val_i : mem_q[rd_idx_i];

  p_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(wr_idx_i)] == $past(wr_val_i));
endmodule

// File: rtl/wl_rotate.sv
module wl_rotate #(
  parameter int unsigned LINE_W = 4
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W-1:0] shift_i,
  output logic [LINE_W-1:0] slot_o
);
  // power-of-two line count: truncation is the modulo
  assign slot_o = line_i + shift_i;
endmodule

// File: rtl/page_line_rotator.sv
module page_line_rotator #(
  parameter int unsigned FRAMES = 64,
  parameter int unsigned LINE_W = 4,
  localparam int unsigned FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               alloc_i,
  input  logic [FRAME_W-1:0] alloc_frame_i,
  input  logic [FRAME_W-1:0] xlat_frame_i,
  input  logic [LINE_W-1:0]  xlat_line_i,
  output logic [LINE_W-1:0]  xlat_line_o
);
  logic [wl_pkg::LFSR_W-1:0] rnd;
  logic [LINE_W-1:0]         shift;

  wl_lfsr u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_o (rnd)
  );

  wl_shift_file #(.FRAMES(FRAMES), .SHIFT_W(LINE_W)) u_file (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (alloc_i),
    .wr_idx_i (alloc_frame_i),
    .wr_val_i (rnd[LINE_W-1:0]),
    .rd_idx_i (xlat_frame_i),
    .rd_val_o (shift)
  );

  wl_rotate #(.LINE_W(LINE_W)) u_rot (
    .line_i  (xlat_line_i),
    .shift_i (shift),
    .slot_o  (xlat_line_o)
  );

  // forwarded value must equal what was stored
  p_bypass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && alloc_frame_i == xlat_frame_i) |=>
      (alloc_i || !$stable(xlat_frame_i) || !$stable(xlat_line_i) || $stable(xlat_line_o)));
endmodule

// File: tb/page_line_rotator_test.sv
module page_line_rotator_test;
  localparam int FRAMES = 64;
  localparam int FW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc = 1'b0;
  logic [FW-1:0] alloc_frame = '0;
  logic [FW-1:0] xlat_frame = '0;
  logic [3:0]    xlat_line = '0;
  logic [3:0]    xlat_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] m_gen;
  logic [3:0]  exp_shift [FRAMES];

  always #4 clk = ~clk;

  page_line_rotator uut (
    .clk_i(clk), .rst_ni(rst_n), .alloc_i(alloc), .alloc_frame_i(alloc_frame),
    .xlat_frame_i(xlat_frame), .xlat_line_i(xlat_line), .xlat_line_o(xlat_out)
  );

  // generator model from R3
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_gen <= 16'hACE1;
    else        m_gen <= {m_gen[14:0], m_gen[15] ^ m_gen[13] ^ m_gen[12] ^ m_gen[10]};
  end

  task automatic cmp(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic probe(input string req, input int f, input int l);
    @(negedge clk);
    xlat_frame = FW'(f);
    xlat_line  = 4'(l);
    #1;
    cmp(req, xlat_out, 4'(l + exp_shift[f]));
  endtask

  task automatic do_alloc(input int f);
    @(negedge clk);
    alloc = 1'b1;
    alloc_frame = FW'(f);
    exp_shift[f] = m_gen[3:0];
    @(negedge clk);
    alloc = 1'b0;
  endtask

  task automatic t_reset;   // R1
    for (int f = 0; f < FRAMES; f += 9) probe("R1", f, f % 16);
    for (int l = 0; l < 16; l++) probe("R1", 0, l);
  endtask

  task automatic t_capture; // R3, R2
    do_alloc(3);
    for (int l = 0; l < 16; l++) probe("R2", 3, l);
    repeat (5) @(negedge clk);
    do_alloc(40);
    probe("R3", 40, 0);
    probe("R3", 40, 15);
  endtask

  task automatic t_hold;    // R4, R7
    logic [3:0] keep3;
    keep3 = exp_shift[3];
    repeat (37) @(negedge clk);
    probe("R4", 3, 7);
    do_alloc(4);
    do_alloc(2);
    do_alloc(63);
    exp_shift[3] = keep3;
    probe("R7", 3, 1);
    probe("R7", 40, 9);
    probe("R7", 5, 11);
  endtask

  task automatic t_realloc; // R5
    for (int k = 0; k < 6; k++) begin
      repeat (k + 1) @(negedge clk);
      do_alloc(3);
      probe("R5", 3, 0);
      probe("R5", 3, 13);
    end
  endtask

  task automatic t_bypass;  // R6
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      alloc = 1'b1;
      alloc_frame = FW'(20 + k);
      xlat_frame = FW'(20 + k);
      xlat_line = 4'(k * 5);
      exp_shift[20 + k] = m_gen[3:0];
      #1;
      cmp("R6", xlat_out, 4'(k * 5 + exp_shift[20 + k]));
      @(negedge clk);
      alloc = 1'b0;
      #1;
      cmp("R6", xlat_out, 4'(k * 5 + exp_shift[20 + k]));
    end
  endtask

  initial begin
    for (int f = 0; f < FRAMES; f++) exp_shift[f] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_capture();
    t_hold();
    t_realloc();
    t_bypass();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule